// File: doc/BRIEF.md
# Descriptor Ring Walker with Programmable Stride

This block sequences descriptor addresses for the transmit and receive DMA paths of a network controller. Software programs a base address for each ring and a DMA control word whose fields give the burst size of each direction, the inter-frame gap count, a gap-increment enable and, most importantly, the size of one descriptor in each ring. The distance between consecutive descriptors therefore follows the programmed size instead of a fixed length.

A walker per direction is started with a kick pulse. It reads the first word of the descriptor at its current pointer through a shared memory read port with one cycle of latency. If the descriptor is marked ready, the walker presents it to the consumer until the consumer signals completion. The walker then steps to the next descriptor, or back to the ring base when the descriptor carries an end-of-ring flag, and fetches again on its own. A descriptor that is not ready stops the walk until the next kick. Control words that would make either descriptor smaller than four 32-bit words are refused, the old setting is kept, and a sticky error flag records the refusal.

Top module: `ring_walker_top`

## Requirements
- R1: After reset the control register (address 0) reads 0x00022000 (16-byte descriptors in both rings), both bases (addresses 1 and 2), both pointers (addresses 3 and 4) and the status register (address 5) read 0, no descriptor is presented and no memory read is issued.
- R2: The control fields drive the outputs: receive burst from bits [9:8], transmit burst from bits [11:10], gap count from bits [22:20], gap-increment enable from bit 23.
- R3: A control write whose transmit size field (bits [19:16]) or receive size field (bits [15:12]) is below 2 is refused and the register keeps its previous value; a value of 2 or more in both fields is accepted. Descriptor size in bytes is the field times 8.
- R4: A refused control write sets bit 0 of the status register; the bit stays set until a status write with bit 0 equal to 1; a status write with bit 0 equal to 0 leaves it unchanged.
- R5: Writing a ring base loads that ring's pointer with the written value in the same cycle and returns its walker to idle, dropping any presented descriptor.
- R6: A kick on an idle walker issues a memory read at its pointer one cycle later (when granted); the read data is taken on the following cycle. Word bit 31 means ready, bit 30 means end of ring.
- R7: A ready descriptor is presented (valid, address, first word) and held unchanged until the done input is seen.
- R8: On done for a descriptor without end-of-ring, the pointer advances by that ring's descriptor size and the next fetch starts automatically.
- R9: On done for a descriptor with end-of-ring, the pointer returns to the ring base.
- R10: A fetched descriptor without the ready bit stops the walker with its pointer unchanged and nothing presented; kicks while a walker is busy are ignored.
- R11: When both walkers request the read port in the same cycle, the transmit walker is served first and the receive walker in the next free cycle.
- R12: The pointer registers at addresses 3 and 4 read back the current pointers; writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| tx_kick | input | 1 | Start the transmit walker |
| tx_done | input | 1 | Transmit descriptor completed |
| tx_desc_valid | output | 1 | Transmit descriptor presented |
| tx_desc_addr | output | AW | Transmit pointer |
| tx_desc_word | output | 32 | First word of presented transmit descriptor |
| rx_kick | input | 1 | Start the receive walker |
| rx_done | input | 1 | Receive descriptor completed |
| rx_desc_valid | output | 1 | Receive descriptor presented |
| rx_desc_addr | output | AW | Receive pointer |
| rx_desc_word | output | 32 | First word of presented receive descriptor |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | 32 | Read data, one cycle after mem_rd_en |
| tx_burst | output | 2 | Transmit burst size field |
| rx_burst | output | 2 | Receive burst size field |
| ifg_count | output | 3 | Inter-frame gap count field |
| ifg_inc | output | 1 | Gap-increment enable |

## Verification
The assertions take for granted that memory answers every read exactly one cycle after the request and that only one register write arrives per cycle, so a refused control write and a status clear can never coincide. The step and wrap properties also assume done is only meaningful while a descriptor is presented. The bench keeps to this with a fixed-latency memory model, a consumer that raises done only after it has seen a presented descriptor, and a write task that issues one register access at a time.

// File: rtl/ring_walk_pkg.sv
package ring_walk_pkg;

    localparam int REG_W   = 32;
    localparam int NUM_DIR = 2;
    localparam int DIR_TX  = 0;
    localparam int DIR_RX  = 1;

    localparam logic [2:0] RA_CTRL    = 3'd0;
    localparam logic [2:0] RA_TX_BASE = 3'd1;
    localparam logic [2:0] RA_RX_BASE = 3'd2;
    localparam logic [2:0] RA_TX_PTR  = 3'd3;
    localparam logic [2:0] RA_RX_PTR  = 3'd4;
    localparam logic [2:0] RA_STATUS  = 3'd5;

    localparam logic [REG_W-1:0] CTRL_RESET = 32'h0002_2000;
    localparam logic [3:0]       MIN_UNITS  = 4'd2;
    localparam int               UNIT_SHIFT = 3;

    localparam int READY_BIT = 31;
    localparam int EOR_BIT   = 30;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_REQ  = 2'd1,
        W_RESP = 2'd2,
        W_HOLD = 2'd3
    } walk_state_e;

    typedef struct packed {
        logic       gap_inc;
        logic [2:0] gap_count;
        logic [3:0] tx_units;
        logic [3:0] rx_units;
        logic [1:0] tx_burst;
        logic [1:0] rx_burst;
    } ctrl_fields_t;

    // argument holds control bits [23:8]
    function automatic ctrl_fields_t decode_ctrl(input logic [15:0] v);
        ctrl_fields_t f;
        f.rx_burst  = v[1:0];
        f.tx_burst  = v[3:2];
        f.rx_units  = v[7:4];
        f.tx_units  = v[11:8];
        f.gap_count = v[14:12];
        f.gap_inc   = v[15];
        return f;
    endfunction

    function automatic logic ctrl_legal(input logic [15:0] v);
        ctrl_fields_t f;
        f = decode_ctrl(v);
        return (f.tx_units >= MIN_UNITS) && (f.rx_units >= MIN_UNITS);
    endfunction

endpackage

// File: rtl/ring_cfg_regs.sv
module ring_cfg_regs
    import ring_walk_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [2:0]       addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ctrl,
    output logic [AW-1:0]    tx_base,
    output logic [AW-1:0]    rx_base,
    output logic             err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= CTRL_RESET;
            tx_base <= '0;
            rx_base <= '0;
            err     <= 1'b0;
        end else if (we) begin
            case (addr)
                RA_CTRL: begin
                    if (ctrl_legal(wdata[23:8])) ctrl <= wdata;
                    else                         err  <= 1'b1;
                end
                RA_TX_BASE: tx_base <= wdata[AW-1:0];
                RA_RX_BASE: rx_base <= wdata[AW-1:0];
                RA_STATUS:  if (wdata[0]) err <= 1'b0;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ring_walker.sv
module ring_walker
    import ring_walk_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    base,
    input  logic             load_en,
    input  logic [AW-1:0]    load_val,
    input  logic [3:0]       step_units,
    input  logic             kick,
    input  logic             done,
    input  logic             gnt,
    input  logic [REG_W-1:0] rd_data,
    output logic             req,
    output logic [AW-1:0]    ptr,
    output logic             desc_valid,
    output logic [REG_W-1:0] desc_word
);

    walk_state_e      st_q;
    logic [AW-1:0]    ptr_q;
    logic [REG_W-1:0] word_q;
    logic [AW-1:0]    step_bytes;
    logic [AW-1:0]    ptr_next;

    assign step_bytes = AW'({step_units, {UNIT_SHIFT{1'b0}}});
    assign ptr_next   = word_q[EOR_BIT] ? base : ptr_q + step_bytes;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= W_IDLE;
            ptr_q  <= '0;
            word_q <= '0;
        end else if (load_en) begin
            st_q  <= W_IDLE;
            ptr_q <= load_val;
        end else begin
            case (st_q)
                W_IDLE: if (kick) st_q <= W_REQ;
                W_REQ:  if (gnt)  st_q <= W_RESP;
                W_RESP: begin
                    if (rd_data[READY_BIT]) begin
                        word_q <= rd_data;
                        st_q   <= W_HOLD;
                    end else begin
                        st_q <= W_IDLE;
                    end
                end
                W_HOLD: begin
                    if (done) begin
                        ptr_q <= ptr_next;
                        st_q  <= W_REQ;
                    end
                end
                default: st_q <= W_IDLE;
            endcase
        end
    end

    assign req        = (st_q == W_REQ);
    assign desc_valid = (st_q == W_HOLD);
    assign ptr        = ptr_q;
    assign desc_word  = word_q;

endmodule

// File: rtl/ring_fetch_arb.sv
module ring_fetch_arb #(
    parameter int AW = 32,
    parameter int N  = 2
) (
    input  logic [N-1:0]         req,
    input  logic [N-1:0][AW-1:0] addr,
    output logic [N-1:0]         gnt,
    output logic                 mem_en,
    output logic [AW-1:0]        mem_addr
);

    // lowest index has priority
    always_comb begin
        gnt      = '0;
        mem_addr = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt      = '0;
                gnt[i]   = 1'b1;
                mem_addr = addr[i];
            end
        end
    end

    assign mem_en = |req;

endmodule

// File: rtl/ring_walker_top.sv
module ring_walker_top
    import ring_walk_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             tx_kick,
    input  logic             tx_done,
    output logic             tx_desc_valid,
    output logic [AW-1:0]    tx_desc_addr,
    output logic [REG_W-1:0] tx_desc_word,
    input  logic             rx_kick,
    input  logic             rx_done,
    output logic             rx_desc_valid,
    output logic [AW-1:0]    rx_desc_addr,
    output logic [REG_W-1:0] rx_desc_word,
    output logic             mem_rd_en,
    output logic [AW-1:0]    mem_rd_addr,
    input  logic [REG_W-1:0] mem_rd_data,
    output logic [1:0]       tx_burst,
    output logic [1:0]       rx_burst,
    output logic [2:0]       ifg_count,
    output logic             ifg_inc
);

    logic [REG_W-1:0] ctrl_q;
    logic [AW-1:0]    tx_base_q;
    logic [AW-1:0]    rx_base_q;
    logic             err_q;
    ctrl_fields_t     fields;

    logic [NUM_DIR-1:0]            kick_v, done_v, req_v, gnt_v, valid_v;
    logic [NUM_DIR-1:0][AW-1:0]    ptr_a;
    logic [NUM_DIR-1:0][REG_W-1:0] word_a;

    ring_cfg_regs #(.AW(AW)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .ctrl    (ctrl_q),
        .tx_base (tx_base_q),
        .rx_base (rx_base_q),
        .err     (err_q)
    );

    assign fields = decode_ctrl(ctrl_q[23:8]);

    assign kick_v[DIR_TX] = tx_kick;
    assign kick_v[DIR_RX] = rx_kick;
    assign done_v[DIR_TX] = tx_done;
    assign done_v[DIR_RX] = rx_done;

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        localparam bit IS_TX = (d == DIR_TX);
        logic [3:0]    units;
        logic          ld;
        logic [AW-1:0] base_cur;

        assign units    = IS_TX ? fields.tx_units : fields.rx_units;
        assign ld       = reg_we && (reg_addr == (IS_TX ? RA_TX_BASE : RA_RX_BASE));
        assign base_cur = IS_TX ? tx_base_q : rx_base_q;

        ring_walker #(.AW(AW)) u_walk (
            .clk        (clk),
            .rst        (rst),
            .base       (base_cur),
            .load_en    (ld),
            .load_val   (reg_wdata[AW-1:0]),
            .step_units (units),
            .kick       (kick_v[d]),
            .done       (done_v[d]),
            .gnt        (gnt_v[d]),
            .rd_data    (mem_rd_data),
            .req        (req_v[d]),
            .ptr        (ptr_a[d]),
            .desc_valid (valid_v[d]),
            .desc_word  (word_a[d])
        );
    end

    ring_fetch_arb #(.AW(AW), .N(NUM_DIR)) u_arb (
        .req      (req_v),
        .addr     (ptr_a),
        .gnt      (gnt_v),
        .mem_en   (mem_rd_en),
        .mem_addr (mem_rd_addr)
    );

    assign tx_desc_valid = valid_v[DIR_TX];
    assign tx_desc_addr  = ptr_a[DIR_TX];
    assign tx_desc_word  = word_a[DIR_TX];
    assign rx_desc_valid = valid_v[DIR_RX];
    assign rx_desc_addr  = ptr_a[DIR_RX];
    assign rx_desc_word  = word_a[DIR_RX];

    assign tx_burst  = fields.tx_burst;
    assign rx_burst  = fields.rx_burst;
    assign ifg_count = fields.gap_count;
    assign ifg_inc   = fields.gap_inc;

    always_comb begin
        case (reg_addr)
            RA_CTRL:    reg_rdata = ctrl_q;
            RA_TX_BASE: reg_rdata = REG_W'(tx_base_q);
            RA_RX_BASE: reg_rdata = REG_W'(rx_base_q);
            RA_TX_PTR:  reg_rdata = REG_W'(ptr_a[DIR_TX]);
            RA_RX_PTR:  reg_rdata = REG_W'(ptr_a[DIR_RX]);
            RA_STATUS:  reg_rdata = {{(REG_W-1){1'b0}}, err_q};
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ring_walker_chk.sv
module ring_walker_chk
    import ring_walk_pkg::*;
#(
    parameter int AW = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_we,
    input logic [2:0]       reg_addr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] ctrl,
    input logic             err,
    input logic [AW-1:0]    tx_base,
    input logic             tx_desc_valid,
    input logic             tx_done,
    input logic [AW-1:0]    tx_desc_addr,
    input logic [REG_W-1:0] tx_desc_word,
    input logic             rx_desc_valid,
    input logic             rx_done,
    input logic [AW-1:0]    rx_desc_addr,
    input logic [REG_W-1:0] rx_desc_word,
    input logic             mem_rd_en,
    input logic [AW-1:0]    mem_rd_addr
);

    logic tx_base_wr, rx_base_wr, bad_ctrl_wr, clr_wr;
    assign tx_base_wr  = reg_we && (reg_addr == RA_TX_BASE);
    assign rx_base_wr  = reg_we && (reg_addr == RA_RX_BASE);
    assign bad_ctrl_wr = reg_we && (reg_addr == RA_CTRL) &&
                         ((reg_wdata[19:16] < MIN_UNITS) || (reg_wdata[15:12] < MIN_UNITS));
    assign clr_wr      = reg_we && (reg_addr == RA_STATUS) && reg_wdata[0];

    a_r7_tx_hold: assert property (@(posedge clk) disable iff (rst)
        tx_desc_valid && !tx_done && !tx_base_wr |=>
            tx_desc_valid && $stable(tx_desc_addr) && $stable(tx_desc_word));

    a_r7_rx_hold: assert property (@(posedge clk) disable iff (rst)
        rx_desc_valid && !rx_done && !rx_base_wr |=>
            rx_desc_valid && $stable(rx_desc_addr) && $stable(rx_desc_word));

    a_r3_reject_keeps: assert property (@(posedge clk) disable iff (rst)
        bad_ctrl_wr |=> $stable(ctrl) && err);

    a_r4_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err && !clr_wr |=> err);

    a_r8_tx_step: assert property (@(posedge clk) disable iff (rst)
        tx_desc_valid && tx_done && !tx_desc_word[EOR_BIT] && !tx_base_wr |=>
            tx_desc_addr == $past(tx_desc_addr) + AW'({$past(ctrl[19:16]), 3'b000}));

    a_r9_tx_wrap: assert property (@(posedge clk) disable iff (rst)
        tx_desc_valid && tx_done && tx_desc_word[EOR_BIT] && !tx_base_wr |=>
            tx_desc_addr == tx_base);

    a_r11_port_addr: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (mem_rd_addr == tx_desc_addr) || (mem_rd_addr == rx_desc_addr));

endmodule

bind ring_walker_top ring_walker_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .ctrl          (ctrl_q),
    .err           (err_q),
    .tx_base       (tx_base_q),
    .tx_desc_valid (tx_desc_valid),
    .tx_done       (tx_done),
    .tx_desc_addr  (tx_desc_addr),
    .tx_desc_word  (tx_desc_word),
    .rx_desc_valid (rx_desc_valid),
    .rx_done       (rx_done),
    .rx_desc_addr  (rx_desc_addr),
    .rx_desc_word  (rx_desc_word),
    .mem_rd_en     (mem_rd_en),
    .mem_rd_addr   (mem_rd_addr)
);

// File: tb/tb_ring_walker_top.sv
`timescale 1ns/1ps
module tb_ring_walker_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        tx_kick = 1'b0, tx_done = 1'b0, rx_kick = 1'b0, rx_done = 1'b0;
    logic        tx_desc_valid, rx_desc_valid, mem_rd_en;
    logic [31:0] tx_desc_addr, rx_desc_addr, tx_desc_word, rx_desc_word, mem_rd_addr;
    logic [31:0] mem_rd_data = 32'd0;
    logic [1:0]  tx_burst, rx_burst;
    logic [2:0]  ifg_count;
    logic        ifg_inc;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    ring_walker_top dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_kick(tx_kick), .tx_done(tx_done), .tx_desc_valid(tx_desc_valid),
        .tx_desc_addr(tx_desc_addr), .tx_desc_word(tx_desc_word),
        .rx_kick(rx_kick), .rx_done(rx_done), .rx_desc_valid(rx_desc_valid),
        .rx_desc_addr(rx_desc_addr), .rx_desc_word(rx_desc_word),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .tx_burst(tx_burst), .rx_burst(rx_burst), .ifg_count(ifg_count), .ifg_inc(ifg_inc)
    );

    // memory with one cycle of read latency
    logic [31:0] mem [logic [31:0]];
    always @(posedge clk)
        if (mem_rd_en) mem_rd_data <= mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 32'd0;

    // behavioural reference model
    logic [31:0] m_ctrl, m_tbase, m_rbase, m_tptr, m_rptr, t_word, r_word, md;
    int          t_st, r_st;
    bit          m_err, tx_first;

    always @(posedge clk) begin
        md = mem_rd_data;
        if (rst) begin
            m_ctrl = 32'h0002_2000; m_tbase = 0; m_rbase = 0; m_tptr = 0; m_rptr = 0;
            t_word = 0; r_word = 0; t_st = 0; r_st = 0; m_err = 0;
        end else begin
            tx_first = (t_st == 1);
            if (reg_we && reg_addr == 3'd1) begin
                t_st = 0; m_tptr = reg_wdata;
            end else begin
                case (t_st)
                    0: if (tx_kick) t_st = 1;
                    1: t_st = 2;
                    2: if (md[31]) begin t_word = md; t_st = 3; end else t_st = 0;
                    default: if (tx_done) begin
                        m_tptr = t_word[30] ? m_tbase : m_tptr + 32'(m_ctrl[19:16]) * 8;
                        t_st = 1;
                    end
                endcase
            end
            if (reg_we && reg_addr == 3'd2) begin
                r_st = 0; m_rptr = reg_wdata;
            end else begin
                case (r_st)
                    0: if (rx_kick) r_st = 1;
                    1: if (!tx_first) r_st = 2;
                    2: if (md[31]) begin r_word = md; r_st = 3; end else r_st = 0;
                    default: if (rx_done) begin
                        m_rptr = r_word[30] ? m_rbase : m_rptr + 32'(m_ctrl[15:12]) * 8;
                        r_st = 1;
                    end
                endcase
            end
            if (reg_we) begin
                case (reg_addr)
                    3'd0: if (reg_wdata[19:16] >= 2 && reg_wdata[15:12] >= 2) m_ctrl = reg_wdata;
                          else m_err = 1;
                    3'd1: m_tbase = reg_wdata;
                    3'd2: m_rbase = reg_wdata;
                    3'd5: if (reg_wdata[0]) m_err = 0;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd1: return m_tbase;
            3'd2: return m_rbase;
            3'd3: return m_tptr;
            3'd4: return m_rptr;
            3'd5: return {31'd0, m_err};
            default: return 32'd0;
        endcase
    endfunction

    // compare against the model every cycle
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            chk("R7", "tx_desc_valid", {31'd0, tx_desc_valid}, {31'd0, t_st == 3});
            chk("R8", "tx_desc_addr", tx_desc_addr, m_tptr);
            if (t_st == 3) chk("R7", "tx_desc_word", tx_desc_word, t_word);
            chk("R7", "rx_desc_valid", {31'd0, rx_desc_valid}, {31'd0, r_st == 3});
            chk("R8", "rx_desc_addr", rx_desc_addr, m_rptr);
            if (r_st == 3) chk("R7", "rx_desc_word", rx_desc_word, r_word);
            chk("R6", "mem_rd_en", {31'd0, mem_rd_en}, {31'd0, (t_st == 1) || (r_st == 1)});
            if (t_st == 1 || r_st == 1)
                chk("R11", "mem_rd_addr", mem_rd_addr, (t_st == 1) ? m_tptr : m_rptr);
            chk("R2", "fields", {23'd0, ifg_inc, ifg_count, tx_burst, rx_burst},
                {23'd0, m_ctrl[23], m_ctrl[22:20], m_ctrl[11:10], m_ctrl[9:8]});
            chk("R12", "reg_rdata", reg_rdata, model_rd(reg_addr));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic consume_tx();
        do @(negedge clk); while (!tx_desc_valid);
        repeat (2) @(negedge clk);
        tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic consume_rx();
        do @(negedge clk); while (!rx_desc_valid);
        @(negedge clk);
        rx_done = 1'b1; @(negedge clk); rx_done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog all actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        mem[32'h1000] = 32'h8000_0011;
        mem[32'h1010] = 32'h8000_0022;
        mem[32'h1020] = 32'hC000_0033;
        mem[32'h2000] = 32'h8000_00A0;
        mem[32'h2018] = 32'h8000_00A1;
        mem[32'h2030] = 32'h0000_00A2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(3'd0, v); chk("R1", "ctrl reset", v, 32'h0002_2000);
        rd(3'd5, v); chk("R1", "status reset", v, 32'd0);
        rd(3'd3, v); chk("R1", "tx ptr reset", v, 32'd0);
        chk("R1", "no fetch", {31'd0, mem_rd_en}, 32'd0);

        // R5 base load
        wr(3'd1, 32'h1000);
        wr(3'd2, 32'h2000);
        rd(3'd3, v); chk("R5", "tx ptr load", v, 32'h1000);

        // transmit walk at 16-byte stride, wrap, stop on not-ready
        @(negedge clk); tx_kick = 1'b1; @(negedge clk); tx_kick = 1'b0;
        consume_tx();
        consume_tx();
        do @(negedge clk); while (!tx_desc_valid);
        chk("R8", "tx third addr", tx_desc_addr, 32'h1020);
        mem[32'h1000] = 32'h0000_0000;
        consume_tx();
        repeat (6) @(negedge clk);
        rd(3'd3, v); chk("R9", "tx wrapped ptr", v, 32'h1000);
        chk("R10", "tx stopped", {31'd0, tx_desc_valid}, 32'd0);

        // R2 field decode, R3/R4 refusal and sticky error
        wr(3'd0, 32'h00D4_3900);
        @(negedge clk); #1;
        chk("R2", "burst/gap", {24'd0, ifg_inc, ifg_count, tx_burst, rx_burst}, 32'h0000_00D9);
        wr(3'd0, 32'h00D4_1900);
        rd(3'd0, v); chk("R3", "rx too small kept", v, 32'h00D4_3900);
        rd(3'd5, v); chk("R4", "err set", v, 32'd1);
        wr(3'd5, 32'd0);
        rd(3'd5, v); chk("R4", "err kept on 0", v, 32'd1);
        wr(3'd5, 32'd1);
        rd(3'd5, v); chk("R4", "err cleared", v, 32'd0);
        wr(3'd0, 32'h00C0_3900);
        rd(3'd0, v); chk("R3", "tx too small kept", v, 32'h00D4_3900);
        rd(3'd5, v); chk("R4", "err set again", v, 32'd1);
        wr(3'd5, 32'd1);
        wr(3'd0, 32'h00D2_2900);
        rd(3'd0, v); chk("R3", "minimum accepted", v, 32'h00D2_2900);
        wr(3'd0, 32'h00D4_3900);
        // R12 pointer registers ignore writes
        wr(3'd3, 32'h0000_DEAD);
        rd(3'd3, v); chk("R12", "tx ptr write ignored", v, 32'h1000);

        // R11 both walkers start together
        mem[32'h1000] = 32'h8000_0044;
        @(negedge clk); tx_kick = 1'b1; rx_kick = 1'b1;
        @(negedge clk); tx_kick = 1'b0; rx_kick = 1'b0; #1;
        chk("R11", "tx served first", mem_rd_addr, 32'h1000);
        @(negedge clk); #1;
        chk("R11", "rx served next", mem_rd_addr, 32'h2000);
        fork
            consume_tx();
            begin consume_rx(); consume_rx(); end
        join
        repeat (6) @(negedge clk);
        rd(3'd4, v); chk("R10", "rx stopped at 0x2030", v, 32'h2030);
        chk("R8", "tx 32-byte step", tx_desc_addr, 32'h1020);
        chk("R7", "tx word held", tx_desc_word, 32'hC000_0033);

        // R5 base write while presenting
        wr(3'd1, 32'h3000);
        chk("R5", "tx dropped", {31'd0, tx_desc_valid}, 32'd0);
        rd(3'd3, v); chk("R5", "tx ptr reloaded", v, 32'h3000);

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule